// File: doc/BRIEF.md
# Configuration-Port Watchdog Timer

This block is a watchdog timer that a host reaches only through a byte-wide configuration window made of two I/O addresses: an index port that picks a register number and a data port that reads or writes the picked register. The window stays shut until the host writes a two-byte key to the index port. A separate exit key shuts it again. Inside the window, a global register selects a logical device. The watchdog's own registers answer only while that selection equals the watchdog's device number.

The host arms the watchdog by writing a nonzero count. A later write reloads the count. Writing zero disarms the watchdog. A mode bit sets the count unit to seconds or minutes. A free-running prescaler supplies the second tick, and 60 second ticks make a minute. When an armed count runs out, the block records a status flag and drives a reset pulse of fixed length, provided a global routing bit lets the pulse through. Keyboard and mouse event inputs can each be enabled to reload the count.

Host accesses use a valid/ready request channel. `h_ready` is always high, so the block never applies back-pressure and every request is taken in the cycle it is presented. A read returns on `r_valid`/`r_data` exactly one clock after the request. The read response has no ready signal, so the host must accept it when it appears.

Top module: `wdt_cfgport`

## Requirements
- R1: The window opens only after two index-port (address 0x2E) writes of 0x87 in a row. An index write of any other value after a single 0x87 returns the lock to the start. An index write of 0xAA while the window is open shuts it.
- R2: While the window is shut, data-port (0x2F) writes change nothing and reads of either port return 0xFF. Every read request accepted at 0x2E or 0x2F gives `r_valid` high one clock later. Requests to other addresses give no response.
- R3: While the window is open, an index write stores the register number, and an index read returns it. Register 0x07 holds the device number. Registers 0x30, 0xF5, 0xF6 and 0xF7 accept writes and return their contents only when 0x07 holds 8. Otherwise they read 0x00. Unimplemented registers read 0x00.
- R4: Register 0x2B resets to 0x10. While its bit 4 is 1, `sys_rst` stays low. Clearing the bit routes expiry pulses to `sys_rst`.
- R5: Register 0xF5 reads back all 8 bits as written. Its bit 3 picks the unit: 0 means seconds, 1 means minutes.
- R6: Writing 0x00 to 0xF6 disarms the timer at once. Writing 0x01 to 0xFF loads that count, which both arms the timer and reloads it if it is already running. A read of 0xF6 returns the remaining count.
- R7: The count drops by one on each unit tick, and only while it is nonzero and bit 0 of 0x30 is 1. The second tick comes every CLK_PER_SEC clocks from reset and is never restarted. The minute tick comes on every 60th second tick.
- R8: When a decrement takes the count from 1 to 0, bit 4 of 0xF7 is set. If routing is enabled, `sys_rst` is high for exactly RST_CYCLES clocks from the next edge.
- R9: In 0xF7, bit 6 enables keyboard reload and bit 7 enables mouse reload. An enabled event pulse, arriving while the count is nonzero and the device is active, reloads the last nonzero value written to 0xF6. With both bits at 0, the events have no effect.
- R10: In one cycle, a host write to 0xF6 takes priority over an event reload, and an event reload takes priority over a decrement.
- R11: Bits 7, 6 and 4 of 0xF7 are writable, and its other bits read 0. Writing 0 to bit 4 clears the expiry flag. An expiry in the same cycle as the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Request accepted (always 1) |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | 16 | Host I/O address |
| h_wdata | input | 8 | Host write byte |
| r_valid | output | 1 | Read response valid, one clock after the request |
| r_data | output | 8 | Read response byte |
| kbd_evt | input | 1 | Keyboard event pulse |
| mouse_evt | input | 1 | Mouse event pulse |
| sys_rst | output | 1 | Active-high system reset pulse |

## Verification
The assertions assume the following about the inputs:
- At most one host request per clock.
- The host consumes every read response in the cycle it appears, because there is no ready signal on the response.
- Event inputs are single-clock pulses.
- RST_CYCLES is at least 1.

The bench keeps within these assumptions. It drives one request per access followed by an idle clock, and it pulses events for a single cycle. Its refresh loops are spaced closer together than one second tick, so the expected absence of a reset is deterministic whatever the phase of the free-running prescaler.

// File: rtl/wdtcp_pkg.sv
package wdtcp_pkg;
  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_e;

  localparam logic [7:0] KEY_ENTER = 8'h87;
  localparam logic [7:0] KEY_LEAVE = 8'hAA;
  localparam logic [7:0] RG_DEVSEL = 8'h07;
  localparam logic [7:0] RG_ROUTE  = 8'h2B;
  localparam logic [7:0] RG_ACTIVE = 8'h30;
  localparam logic [7:0] RG_UNIT   = 8'hF5;
  localparam logic [7:0] RG_COUNT  = 8'hF6;
  localparam logic [7:0] RG_EVENT  = 8'hF7;

  localparam int ROUTE_MASK_BIT = 4;
  localparam int UNIT_MIN_BIT   = 3;
  localparam int EVT_MS_BIT     = 7;
  localparam int EVT_KB_BIT     = 6;
  localparam int EVT_FLAG_BIT   = 4;

  typedef struct packed {
    logic idx_wr;
    logic idx_rd;
    logic dat_wr;
    logic dat_rd;
  } hostop_t;
endpackage

// File: rtl/wdtcp_unlock.sv
module wdtcp_unlock
  import wdtcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_on
);
  lock_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LK_SHUT;
    end else if (idx_wr) begin
      unique case (state)
        LK_SHUT: if (wdata == KEY_ENTER) state <= LK_HALF;
        LK_HALF: state <= (wdata == KEY_ENTER) ? LK_OPEN : LK_SHUT;
        LK_OPEN: if (wdata == KEY_LEAVE) state <= LK_SHUT;
        default: state <= LK_SHUT;
      endcase
    end
  end

  assign cfg_on = (state == LK_OPEN);
endmodule

// File: rtl/wdtcp_timebase.sv
module wdtcp_timebase #(
  parameter int unsigned CLK_PER_SEC = 50_000_000,
  parameter int unsigned SEC_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  output logic sec_tick,
  output logic min_tick
);
  localparam int unsigned PW = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
  localparam int unsigned MW = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

  generate
    if (CLK_PER_SEC == 1) begin : g_sec_direct
      assign sec_tick = 1'b1;
    end else begin : g_sec_div
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pre <= '0;
        else if (sec_tick) pre <= '0;
        else               pre <= pre + 1'b1;
      end
      assign sec_tick = (pre == PW'(CLK_PER_SEC - 1));
    end

    if (SEC_PER_MIN == 1) begin : g_min_direct
      assign min_tick = sec_tick;
    end else begin : g_min_div
      logic [MW-1:0] secs;
      logic          last_sec;
      assign last_sec = (secs == MW'(SEC_PER_MIN - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        secs <= '0;
        else if (sec_tick) secs <= last_sec ? '0 : secs + 1'b1;
      end
      assign min_tick = sec_tick && last_sec;
    end
  endgenerate
endmodule

// File: rtl/wdtcp_regs.sv
module wdtcp_regs
  import wdtcp_pkg::*;
#(
  parameter logic [7:0] WDT_DEV = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_on,
  input  hostop_t    op,
  input  logic [7:0] wdata,
  input  logic       expire,
  input  logic [7:0] count,
  output logic       active,
  output logic       route_en,
  output logic       unit_min,
  output logic       kb_en,
  output logic       ms_en,
  output logic       tmo_wr,
  output logic [7:0] tmo_wdata,
  output logic       r_valid,
  output logic [7:0] r_data
);
  logic [7:0] idx;
  logic [7:0] devsel;
  logic [7:0] route;
  logic [7:0] unitreg;
  logic       act_q;
  logic       kb_q, ms_q, flag_q;
  logic       dev_hit;
  logic       wr_ok;
  logic [7:0] rd_sel;

  assign dev_hit = (devsel == WDT_DEV);
  assign wr_ok   = op.dat_wr && cfg_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      devsel  <= '0;
      route   <= 8'h10;
      unitreg <= '0;
      act_q   <= 1'b0;
      kb_q    <= 1'b0;
      ms_q    <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (op.idx_wr && cfg_on) idx <= wdata;
      if (wr_ok) begin
        case (idx)
          RG_DEVSEL: devsel <= wdata;
          RG_ROUTE:  route  <= wdata;
          RG_ACTIVE: if (dev_hit) act_q <= wdata[0];
          RG_UNIT:   if (dev_hit) unitreg <= wdata;
          RG_EVENT: if (dev_hit) begin
            ms_q   <= wdata[EVT_MS_BIT];
            kb_q   <= wdata[EVT_KB_BIT];
            flag_q <= wdata[EVT_FLAG_BIT];
          end
          default: ;
        endcase
      end
      if (expire) flag_q <= 1'b1;
    end
  end

  always_comb begin
    rd_sel = 8'h00;
    case (idx)
      RG_DEVSEL: rd_sel = devsel;
      RG_ROUTE:  rd_sel = route;
      RG_ACTIVE: rd_sel = dev_hit ? {7'b0, act_q} : 8'h00;
      RG_UNIT:   rd_sel = dev_hit ? unitreg : 8'h00;
      RG_COUNT:  rd_sel = dev_hit ? count : 8'h00;
      RG_EVENT:  rd_sel = dev_hit ? {ms_q, kb_q, 1'b0, flag_q, 4'b0000} : 8'h00;
      default:   rd_sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_data  <= 8'h00;
    end else begin
      r_valid <= op.idx_rd || op.dat_rd;
      if (op.idx_rd || op.dat_rd) begin
        if (!cfg_on)        r_data <= 8'hFF;
        else if (op.idx_rd) r_data <= idx;
        else                r_data <= rd_sel;
      end
    end
  end

  assign active    = act_q;
  assign route_en  = !route[ROUTE_MASK_BIT];
  assign unit_min  = unitreg[UNIT_MIN_BIT];
  assign kb_en     = kb_q;
  assign ms_en     = ms_q;
  assign tmo_wr    = wr_ok && dev_hit && (idx == RG_COUNT);
  assign tmo_wdata = wdata;
endmodule

// File: rtl/wdtcp_counter.sv
module wdtcp_counter #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       min_tick,
  input  logic       unit_min,
  input  logic       active,
  input  logic       route_en,
  input  logic       tmo_wr,
  input  logic [7:0] tmo_wdata,
  input  logic       retrig_req,
  output logic [7:0] count,
  output logic       expire,
  output logic       sys_rst
);
  localparam int unsigned RW = $clog2(RST_CYCLES + 1);

  logic [7:0]    reload;
  logic [RW-1:0] rst_left;
  logic          unit_tick;
  logic          running;
  logic          retrig;
  logic          dec;

  assign unit_tick = unit_min ? min_tick : sec_tick;
  assign running   = active && (count != 8'd0);
  assign retrig    = running && retrig_req;
  assign dec       = running && unit_tick;
  assign expire    = !tmo_wr && !retrig && dec && (count == 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= 8'd0;
      reload <= 8'd0;
    end else if (tmo_wr) begin
      count <= tmo_wdata;
      if (tmo_wdata != 8'd0) reload <= tmo_wdata;
    end else if (retrig) begin
      count <= reload;
    end else if (dec) begin
      count <= count - 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rst_left <= '0;
    else if (expire && route_en)   rst_left <= RW'(RST_CYCLES);
    else if (rst_left != '0)       rst_left <= rst_left - 1'b1;
  end

  assign sys_rst = (rst_left != '0) && route_en;
endmodule

// File: rtl/wdt_cfgport.sv
module wdt_cfgport
  import wdtcp_pkg::*;
#(
  parameter logic [15:0] IDX_ADDR    = 16'h002E,
  parameter logic [15:0] DAT_ADDR    = 16'h002F,
  parameter logic [7:0]  WDT_DEV     = 8'h08,
  parameter int unsigned CLK_PER_SEC = 50_000_000,
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned RST_CYCLES  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_valid,
  output logic        h_ready,
  input  logic        h_write,
  input  logic [15:0] h_addr,
  input  logic [7:0]  h_wdata,
  output logic        r_valid,
  output logic [7:0]  r_data,
  input  logic        kbd_evt,
  input  logic        mouse_evt,
  output logic        sys_rst
);
  hostop_t    op;
  logic       cfg_on;
  logic       sec_tick, min_tick;
  logic       active, route_en, unit_min, kb_en, ms_en;
  logic       tmo_wr;
  logic [7:0] tmo_wdata;
  logic [7:0] wdt_count;
  logic       expire;
  logic       hit_idx, hit_dat;

  assign h_ready   = 1'b1;
  assign hit_idx   = h_valid && (h_addr == IDX_ADDR);
  assign hit_dat   = h_valid && (h_addr == DAT_ADDR);
  assign op.idx_wr = hit_idx && h_write;
  assign op.idx_rd = hit_idx && !h_write;
  assign op.dat_wr = hit_dat && h_write;
  assign op.dat_rd = hit_dat && !h_write;

  wdtcp_unlock u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (op.idx_wr),
    .wdata  (h_wdata),
    .cfg_on (cfg_on)
  );

  wdtcp_timebase #(
    .CLK_PER_SEC (CLK_PER_SEC),
    .SEC_PER_MIN (SEC_PER_MIN)
  ) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .min_tick (min_tick)
  );

  wdtcp_regs #(.WDT_DEV(WDT_DEV)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_on    (cfg_on),
    .op        (op),
    .wdata     (h_wdata),
    .expire    (expire),
    .count     (wdt_count),
    .active    (active),
    .route_en  (route_en),
    .unit_min  (unit_min),
    .kb_en     (kb_en),
    .ms_en     (ms_en),
    .tmo_wr    (tmo_wr),
    .tmo_wdata (tmo_wdata),
    .r_valid   (r_valid),
    .r_data    (r_data)
  );

  wdtcp_counter #(.RST_CYCLES(RST_CYCLES)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .min_tick   (min_tick),
    .unit_min   (unit_min),
    .active     (active),
    .route_en   (route_en),
    .tmo_wr     (tmo_wr),
    .tmo_wdata  (tmo_wdata),
    .retrig_req ((kbd_evt && kb_en) || (mouse_evt && ms_en)),
    .count      (wdt_count),
    .expire     (expire),
    .sys_rst    (sys_rst)
  );
endmodule

// File: rtl/wdtcp_checker.sv
module wdtcp_checker #(
  parameter logic [15:0] IDX_ADDR   = 16'h002E,
  parameter logic [15:0] DAT_ADDR   = 16'h002F,
  parameter int unsigned RST_CYCLES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        h_valid,
  input logic        h_write,
  input logic [15:0] h_addr,
  input logic        r_valid,
  input logic [7:0]  r_data,
  input logic        cfg_on,
  input logic [7:0]  wdt_count,
  input logic        tmo_wr,
  input logic [7:0]  tmo_wdata,
  input logic        route_en,
  input logic        sys_rst
);
  logic rd_req;
  int unsigned hi_len;

  assign rd_req = h_valid && !h_write && (h_addr == IDX_ADDR || h_addr == DAT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len <= 0;
    else if (sys_rst) hi_len <= hi_len + 1;
    else              hi_len <= 0;
  end

  // R2: a response follows each accepted read one clock later, and only then
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> r_valid);
  p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !r_valid);
  // R2: a locked window answers 0xFF
  p_locked_reads_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !cfg_on) |=> (r_data == 8'hFF));
  // R6: a count write lands in the next cycle, zero disarms
  p_count_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_wr |=> (wdt_count == $past(tmo_wdata)));
  p_zero_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_wr && tmo_wdata == 8'h00) |=> (wdt_count == 8'h00));
  // R7: without a host write the count only falls one step at a time
  p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tmo_wr) && wdt_count < $past(wdt_count)) |-> (wdt_count == $past(wdt_count) - 8'd1));
  // R4: a masked route keeps the reset output low
  p_masked_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> route_en);
  // R8: the reset pulse never outlasts its length
  p_pulse_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> (hi_len < RST_CYCLES));
endmodule

bind wdt_cfgport wdtcp_checker #(
  .IDX_ADDR   (IDX_ADDR),
  .DAT_ADDR   (DAT_ADDR),
  .RST_CYCLES (RST_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .h_valid   (h_valid),
  .h_write   (h_write),
  .h_addr    (h_addr),
  .r_valid   (r_valid),
  .r_data    (r_data),
  .cfg_on    (cfg_on),
  .wdt_count (wdt_count),
  .tmo_wr    (tmo_wr),
  .tmo_wdata (tmo_wdata),
  .route_en  (route_en),
  .sys_rst   (sys_rst)
);

// File: tb/wdt_cfgport_tb.sv
module wdt_cfgport_tb;
  localparam int CPS = 20;
  localparam int RC  = 4;
  localparam logic [15:0] PI = 16'h002E;
  localparam logic [15:0] PD = 16'h002F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_valid = 1'b0, h_write = 1'b0;
  logic [15:0] h_addr = '0;
  logic [7:0] h_wdata = '0;
  logic kbd_evt = 1'b0, mouse_evt = 1'b0;
  logic h_ready, r_valid, sys_rst;
  logic [7:0] r_data;

  int checks = 0, fails = 0;
  int pulses = 0, cur_len = 0, last_len = 0;
  logic prev_rst = 1'b0;

  always #10 clk = ~clk;

  wdt_cfgport #(.CLK_PER_SEC(CPS), .RST_CYCLES(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
    .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata),
    .r_valid(r_valid), .r_data(r_data), .kbd_evt(kbd_evt),
    .mouse_evt(mouse_evt), .sys_rst(sys_rst)
  );

  // ---------------- behavioural reference model ----------------
  int m_lock, m_pre, m_secs, m_rleft;
  logic [7:0] m_idx, m_dev, m_route, m_unit, m_cnt, m_rel, m_rd;
  logic m_act, m_kb, m_ms, m_flag, m_rv;
  logic m_sys;

  function automatic logic [7:0] m_reg(input logic [7:0] i);
    logic d;
    d = (m_dev == 8'h08);
    case (i)
      8'h07: return m_dev;
      8'h2B: return m_route;
      8'h30: return d ? {7'b0, m_act} : 8'h00;
      8'hF5: return d ? m_unit : 8'h00;
      8'hF6: return d ? m_cnt : 8'h00;
      8'hF7: return d ? {m_ms, m_kb, 1'b0, m_flag, 4'b0} : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic ai, ad, op, dv, sec, mint, tick, f6w, rtg, dec, ex;
    if (!rst_n) begin
      m_lock = 0; m_pre = 0; m_secs = 0; m_rleft = 0;
      m_idx = 0; m_dev = 0; m_route = 8'h10; m_unit = 0; m_cnt = 0; m_rel = 0;
      m_act = 0; m_kb = 0; m_ms = 0; m_flag = 0; m_rv = 0; m_rd = 0;
    end else begin
      ai = h_valid && h_addr == PI;
      ad = h_valid && h_addr == PD;
      op = (m_lock == 2);
      dv = (m_dev == 8'h08);
      m_rv = (ai || ad) && !h_write;
      if (m_rv) m_rd = !op ? 8'hFF : (ai ? m_idx : m_reg(m_idx));
      sec  = (m_pre == CPS - 1);
      mint = sec && (m_secs == 59);
      tick = m_unit[3] ? mint : sec;
      f6w  = ad && h_write && op && dv && m_idx == 8'hF6;
      rtg  = ((kbd_evt && m_kb) || (mouse_evt && m_ms)) && m_cnt != 0 && m_act;
      dec  = tick && m_cnt != 0 && m_act;
      ex   = !f6w && !rtg && dec && m_cnt == 1;
      if (ex && !m_route[4]) m_rleft = RC;
      else if (m_rleft > 0) m_rleft = m_rleft - 1;
      if (f6w) begin
        m_cnt = h_wdata;
        if (h_wdata != 0) m_rel = h_wdata;
      end else if (rtg) m_cnt = m_rel;
      else if (dec) m_cnt = m_cnt - 1;
      if (ad && h_write && op) begin
        case (m_idx)
          8'h07: m_dev = h_wdata;
          8'h2B: m_route = h_wdata;
          8'h30: if (dv) m_act = h_wdata[0];
          8'hF5: if (dv) m_unit = h_wdata;
          8'hF7: if (dv) begin m_ms = h_wdata[7]; m_kb = h_wdata[6]; m_flag = h_wdata[4]; end
          default: ;
        endcase
      end
      if (ex) m_flag = 1'b1;
      if (ai && h_write && op) m_idx = h_wdata;
      if (ai && h_write) begin
        case (m_lock)
          0: if (h_wdata == 8'h87) m_lock = 1;
          1: m_lock = (h_wdata == 8'h87) ? 2 : 0;
          default: if (h_wdata == 8'hAA) m_lock = 0;
        endcase
      end
      m_pre = sec ? 0 : m_pre + 1;
      if (sec) m_secs = (m_secs == 59) ? 0 : m_secs + 1;
    end
    m_sys = (m_rleft != 0) && !m_route[4];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(sys_rst === m_sys, "R8 reset output vs model", {31'b0, sys_rst}, {31'b0, m_sys});
      if (r_valid || m_rv)
        chk(r_valid === m_rv && r_data === m_rd, "R3 read response vs model",
            {23'b0, r_valid, r_data}, {23'b0, m_rv, m_rd});
      if (sys_rst && !prev_rst) begin pulses++; cur_len = 1; end
      else if (sys_rst) cur_len++;
      if (sys_rst) last_len = cur_len;
      prev_rst = sys_rst;
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    h_valid = 1'b1; h_write = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_valid = 1'b0; h_write = 1'b0;
  endtask

  task automatic rd_expect(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    h_valid = 1'b1; h_write = 1'b0; h_addr = a;
    @(negedge clk);
    h_valid = 1'b0;
    chk(r_valid === 1'b1 && r_data === exp, tag, {23'b0, r_valid, r_data}, {23'b0, 1'b1, exp});
  endtask

  task automatic rd_nonzero(input logic [15:0] a, input string tag);
    @(negedge clk);
    h_valid = 1'b1; h_write = 1'b0; h_addr = a;
    @(negedge clk);
    h_valid = 1'b0;
    chk(r_valid === 1'b1 && r_data !== 8'h00, tag, {24'b0, r_data}, 32'h1);
  endtask

  task automatic pulse_evt(input bit kb);
    @(negedge clk);
    if (kb) kbd_evt = 1'b1; else mouse_evt = 1'b1;
    @(negedge clk);
    kbd_evt = 1'b0; mouse_evt = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(sys_rst === 1'b0, "R8 reset state low", {31'b0, sys_rst}, 0);
    // R2: locked window
    rd_expect(PD, 8'hFF, "R2 locked data read");
    rd_expect(PI, 8'hFF, "R2 locked index read");
    wr(PI, 8'h07); wr(PD, 8'h08);
    // R1: partial key
    wr(PI, 8'h87); wr(PI, 8'h07);
    rd_expect(PI, 8'hFF, "R1 partial key stays locked");
    wr(PI, 8'h87); wr(PI, 8'h87);
    rd_expect(PI, 8'h00, "R1 open window reads index");
    wr(PI, 8'h07);
    rd_expect(PD, 8'h00, "R2 locked write ignored");
    // R3: device selection gating
    wr(PD, 8'h03);
    wr(PI, 8'hF5); wr(PD, 8'h55);
    rd_expect(PD, 8'h00, "R3 other device reads zero");
    wr(PI, 8'h30); wr(PD, 8'h01);
    wr(PI, 8'h07); wr(PD, 8'h08);
    rd_expect(PD, 8'h08, "R3 device number readback");
    wr(PI, 8'hF5);
    rd_expect(PD, 8'h00, "R3 write under other device ignored");
    wr(PI, 8'h30);
    rd_expect(PD, 8'h00, "R3 activate under other device ignored");
    wr(PI, 8'h2B);
    rd_expect(PD, 8'h10, "R4 route register reset value");
    wr(PI, 8'hF5); wr(PD, 8'h37);
    rd_expect(PD, 8'h37, "R5 unit register readback");
    wr(PI, 8'hF6); wr(PD, 8'h03);
    rd_expect(PD, 8'h03, "R6 count load, R7 inactive holds");
    wr(PI, 8'h30); wr(PD, 8'h01);
    repeat (100) @(negedge clk);
    chk(pulses == 0, "R4 masked route no pulse", pulses, 0);
    wr(PI, 8'hF7);
    rd_expect(PD, 8'h10, "R8 expiry flag set");
    wr(PI, 8'hF6);
    rd_expect(PD, 8'h00, "R8 count ends at zero");
    wr(PI, 8'hF7); wr(PD, 8'h00);
    rd_expect(PD, 8'h00, "R11 flag cleared by write");
    // R8: routed expiry
    wr(PI, 8'h2B); wr(PD, 8'h00);
    wr(PI, 8'hF6); wr(PD, 8'h02);
    repeat (80) @(negedge clk);
    chk(pulses == 1, "R8 routed expiry pulse", pulses, 1);
    chk(last_len == RC, "R8 pulse length", last_len, RC);
    // R6: disarm
    wr(PD, 8'h05); repeat (10) @(negedge clk); wr(PD, 8'h00);
    repeat (150) @(negedge clk);
    chk(pulses == 1, "R6 zero write disarms", pulses, 1);
    rd_expect(PD, 8'h00, "R6 disarmed count");
    // R6: refresh
    wr(PD, 8'h02);
    for (int i = 0; i < 8; i++) begin repeat (15) @(negedge clk); wr(PD, 8'h02); end
    chk(pulses == 1, "R6 refresh prevents expiry", pulses, 1);
    wr(PD, 8'h00);
    // R9: events
    wr(PI, 8'hF7); wr(PD, 8'h00); wr(PI, 8'hF6); wr(PD, 8'h02);
    for (int i = 0; i < 8; i++) begin repeat (8) @(negedge clk); pulse_evt(1'b1); pulse_evt(1'b0); end
    chk(pulses == 2, "R9 disabled events no effect", pulses, 2);
    wr(PI, 8'hF7); wr(PD, 8'h40); wr(PI, 8'hF6); wr(PD, 8'h02);
    for (int i = 0; i < 10; i++) begin repeat (11) @(negedge clk); pulse_evt(1'b1); end
    chk(pulses == 2, "R9 keyboard reload", pulses, 2);
    for (int i = 0; i < 6; i++) begin repeat (11) @(negedge clk); pulse_evt(1'b0); end
    chk(pulses == 3, "R9 mouse not enabled", pulses, 3);
    wr(PI, 8'hF7); wr(PD, 8'h80);
    rd_expect(PD, 8'h80, "R11 event enable bits");
    wr(PI, 8'hF6); wr(PD, 8'h02);
    for (int i = 0; i < 10; i++) begin repeat (11) @(negedge clk); pulse_evt(1'b0); end
    chk(pulses == 3, "R9 mouse reload", pulses, 3);
    // R10: continual writes win over ticks
    for (int i = 0; i < 60; i++) wr(PD, 8'h02);
    chk(pulses == 3, "R10 write priority", pulses, 3);
    wr(PD, 8'h00);
    // R7: minutes
    wr(PI, 8'hF5); wr(PD, 8'h08); wr(PI, 8'hF6); wr(PD, 8'h02);
    repeat (200) @(negedge clk);
    rd_nonzero(PD, "R7 minute unit slow");
    repeat (2600) @(negedge clk);
    chk(pulses == 4, "R7 minute expiry", pulses, 4);
    // R7: inactive holds
    wr(PI, 8'hF5); wr(PD, 8'h00); wr(PI, 8'h30); wr(PD, 8'h00);
    wr(PI, 8'hF6); wr(PD, 8'h01);
    repeat (100) @(negedge clk);
    chk(pulses == 4, "R7 inactive no expiry", pulses, 4);
    rd_expect(PD, 8'h01, "R7 inactive count held");
    // R1: leave key
    wr(PI, 8'hAA);
    rd_expect(PD, 8'hFF, "R1 leave key locks");
    rd_expect(PI, 8'hFF, "R1 index locked");
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule